// File: doc/BRIEF.md
# TDM time-slot routing engine

This block sorts the time slots of a TDM frame between a set of internal serial channels. Each TDM port has a route table for receive and a separate one for transmit. A route table is a run-length list. Each entry names how many consecutive slots it covers and which channel owns them. The engine steps through the table while slots arrive from the serial front end. It hands each received slot byte to the owning channel. For each transmit slot it takes the byte presented by the owning channel. Slots that belong to nobody are discarded on receive and filled with an idle byte on transmit.

The front end supplies, per port and per direction, a frame-start pulse and a slot-event pulse. Every slot is 8 bits, and a receive slot event comes with the completed byte. Software-side loading uses one write port that addresses a port, a direction and an entry index. Writes land in a shadow table. The shadow table is copied into the working table at the next frame start of that port and direction, so a half-written table never steers a frame in progress.

Each table walker is a three-state machine. WAIT is the state after reset, before any frame start. RUN means an entry is in force. END means the table has run out. A frame start takes any state to RUN if the new entry 0 has a non-zero count, and to END otherwise. In RUN, a slot event that consumes the last slot of an entry either reloads the next entry (RUN to RUN) or goes to END. That happens when the next entry is a terminator or the last table index has been used. Only RUN produces a target other than "not used".

Top module: `tsr_router`

## Requirements
- R1: After reset all outputs are zero and every table is empty. Slot events that arrive before the first frame start of their port and direction are treated as not used.
- R2: A table write is accepted only when its flags field is zero, its target code is at most 5 and its count is at most 64. Any other write leaves the table unchanged. A stored count of 0 marks the end of the table.
- R3: Entries apply in index order from slot 0. Slot k of a frame belongs to the entry whose cumulative run covers k. For example, runs of 2, 24, 1 and 5 cover slots 0-1, 2-25, 26 and 27-31.
- R4: Target code 0 means not used. Codes 1 to 5 select channel code-1. For port p, that channel's strobe is bit p*5+code-1 of `rx_dlv` or `tx_pull`.
- R5: One cycle after a receive slot event, exactly one `rx_dlv` bit of that port pulses and `rx_data` carries the slot byte. For a not-used slot no bit pulses and `rx_data` keeps its value.
- R6: One cycle after a transmit slot event, `tx_vld` of that port pulses. `tx_data` carries the owning channel's byte as presented on `ch_tx_data` in the event cycle, and that channel's `tx_pull` bit pulses. A not-used slot sends 0xFF with no pull.
- R7: Slots after a terminator entry, or after the 64th entry, are not used until the next frame start.
- R8: A table write affects nothing until the next frame start of that port and direction. A write in the same cycle as a frame start is held for the frame after.
- R9: A frame start returns the walk to slot 0. A slot event in the same cycle as a frame start is dropped and produces no output.
- R10: Each of the two ports and each direction has its own table and walk. Activity on one has no effect on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_port | input | 1 | TDM port addressed by the write |
| cfg_tx | input | 1 | 1 selects the transmit table, 0 the receive table |
| cfg_idx | input | 6 | Entry index |
| cfg_cnt | input | 7 | Slot count of the entry (0 terminates) |
| cfg_tgt | input | 3 | Target code |
| cfg_flags | input | 4 | Reserved flags, must be zero |
| rx_fs | input | 2 | Receive frame start, one bit per port |
| rx_slot | input | 2 | Receive slot completed, one bit per port |
| rx_byte | input | 16 | Received slot byte, 8 bits per port |
| tx_fs | input | 2 | Transmit frame start, one bit per port |
| tx_slot | input | 2 | Transmit slot event, one bit per port |
| ch_tx_data | input | 40 | Byte offered by each of the 5 channels |
| rx_dlv | output | 10 | Delivery strobe per port and channel |
| rx_data | output | 16 | Delivered byte per port |
| tx_vld | output | 2 | Transmit byte valid per port |
| tx_data | output | 16 | Transmit byte per port |
| tx_pull | output | 10 | Pull strobe per port and channel |

## Verification
The first pattern is a table with unused gaps between channel runs, driven by back-to-back slots and then by slots with idle cycles between them. It separates correct run boundaries and pointer advance from off-by-one errors at each entry edge. A second pattern uses a full 64-entry table of single-slot runs. Together with tables that end early, it shows whether the walk stops at the terminator and at the last index rather than wrapping. Shadow behaviour is tried with writes in the middle of a frame and in the same cycle as a frame start. Rejected writes with bad flags, bad targets or oversize counts show whether the acceptance checks hold. Frame starts that coincide with slots, and frames on one port restarted while the other runs, separate the drop rule and port independence from a shared walk.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int MAX_RUN = 64;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);
    localparam int TGT_W   = 3;
    localparam int FLAG_W  = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [TGT_W-1:0] tgt;
    } route_t;
endpackage

// File: rtl/tsr_table.sv
module tsr_table
    import tsr_pkg::*;
#(
    parameter int NENT = 64,
    localparam int IW  = $clog2(NENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  route_t           wr_ent,
    input  logic             swap,
    input  logic [IW-1:0]    cur_idx,
    input  logic [IW-1:0]    nxt_idx,
    output logic [TGT_W-1:0] cur_tgt,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic [CNT_W-1:0] head_cnt
);
    route_t shadow_q [NENT];
    route_t active_q [NENT];

    // Shadow copy: writes go here, copied to the working table at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end
        end else begin
            if (swap) begin
                for (int i = 0; i < NENT; i++) active_q[i] <= shadow_q[i];
            end
            if (wr_en) shadow_q[wr_idx] <= wr_ent;
        end
    end

    assign cur_tgt  = active_q[cur_idx].tgt;
    assign nxt_cnt  = active_q[nxt_idx].cnt;
    assign head_cnt = shadow_q[0].cnt;
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker
    import tsr_pkg::*;
#(
    parameter int NENT = 64,
    localparam int IW  = $clog2(NENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             slot_evt,
    input  logic [CNT_W-1:0] head_cnt,
    input  logic [TGT_W-1:0] cur_tgt,
    input  logic [CNT_W-1:0] nxt_cnt,
    output logic [IW-1:0]    ptr,
    output logic [TGT_W-1:0] tgt,
    output logic             take
);
    typedef enum logic [1:0] {W_WAIT, W_RUN, W_END} wstate_t;

    localparam logic [IW-1:0] LAST = IW'(NENT - 1);

    wstate_t          st_q, st_n;
    logic [IW-1:0]    ptr_q, ptr_n;
    logic [CNT_W-1:0] rem_q, rem_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= W_WAIT;
            ptr_q <= '0;
            rem_q <= '0;
        end else begin
            st_q  <= st_n;
            ptr_q <= ptr_n;
            rem_q <= rem_n;
        end
    end

    // Next state
    always_comb begin
        st_n  = st_q;
        ptr_n = ptr_q;
        rem_n = rem_q;
        if (frame_start) begin
            ptr_n = '0;
            rem_n = head_cnt;
            st_n  = (head_cnt != '0) ? W_RUN : W_END;
        end else begin
            unique case (st_q)
                W_WAIT: ;
                W_RUN: begin
                    if (slot_evt) begin
                        if (rem_q == CNT_W'(1)) begin
                            if (ptr_q == LAST || nxt_cnt == '0) begin
                                st_n = W_END;
                            end else begin
                                ptr_n = ptr_q + IW'(1);
                                rem_n = nxt_cnt;
                            end
                        end else begin
                            rem_n = rem_q - CNT_W'(1);
                        end
                    end
                end
                W_END: ;
                default: st_n = W_WAIT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ptr  = ptr_q;
        tgt  = (st_q == W_RUN) ? cur_tgt : '0;
        take = slot_evt & ~frame_start;
    end
endmodule

// File: rtl/tsr_rx_lane.sv
module tsr_rx_lane
    import tsr_pkg::*;
#(
    parameter int NCH    = 5,
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [TGT_W-1:0]  tgt,
    input  logic [SLOT_W-1:0] byte_in,
    output logic [NCH-1:0]    strb,
    output logic [SLOT_W-1:0] data
);
    logic [NCH-1:0] strb_n;

    always_comb begin
        for (int c = 0; c < NCH; c++) strb_n[c] = take && (tgt == TGT_W'(c + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb <= '0;
            data <= '0;
        end else begin
            strb <= strb_n;
            if (|strb_n) data <= byte_in;
        end
    end
endmodule

// File: rtl/tsr_tx_lane.sv
module tsr_tx_lane
    import tsr_pkg::*;
#(
    parameter int NCH    = 5,
    parameter int SLOT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [TGT_W-1:0]      tgt,
    input  logic [NCH*SLOT_W-1:0] src,
    output logic [NCH-1:0]        pull,
    output logic                  vld,
    output logic [SLOT_W-1:0]     data
);
    logic [NCH-1:0]    pull_n;
    logic [SLOT_W-1:0] pick;

    always_comb begin
        pick = '1;
        for (int c = 0; c < NCH; c++) begin
            pull_n[c] = take && (tgt == TGT_W'(c + 1));
            if (tgt == TGT_W'(c + 1)) pick = src[c*SLOT_W +: SLOT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull <= '0;
            vld  <= 1'b0;
            data <= '0;
        end else begin
            pull <= pull_n;
            vld  <= take;
            if (take) data <= pick;
        end
    end
endmodule

// File: rtl/tsr_router.sv
module tsr_router
    import tsr_pkg::*;
#(
    parameter int NPORT  = 2,
    parameter int NENT   = 64,
    parameter int NCH    = 5,
    parameter int SLOT_W = 8,
    localparam int IW    = $clog2(NENT),
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [PW-1:0]           cfg_port,
    input  logic                    cfg_tx,
    input  logic [IW-1:0]           cfg_idx,
    input  logic [CNT_W-1:0]        cfg_cnt,
    input  logic [TGT_W-1:0]        cfg_tgt,
    input  logic [FLAG_W-1:0]       cfg_flags,
    input  logic [NPORT-1:0]        rx_fs,
    input  logic [NPORT-1:0]        rx_slot,
    input  logic [NPORT*SLOT_W-1:0] rx_byte,
    input  logic [NPORT-1:0]        tx_fs,
    input  logic [NPORT-1:0]        tx_slot,
    input  logic [NCH*SLOT_W-1:0]   ch_tx_data,
    output logic [NPORT*NCH-1:0]    rx_dlv,
    output logic [NPORT*SLOT_W-1:0] rx_data,
    output logic [NPORT-1:0]        tx_vld,
    output logic [NPORT*SLOT_W-1:0] tx_data,
    output logic [NPORT*NCH-1:0]    tx_pull
);
    logic   cfg_ok;
    route_t cfg_ent;

    assign cfg_ok = cfg_we && (cfg_flags == '0) && (cfg_tgt <= TGT_W'(NCH))
                    && (cfg_cnt <= CNT_W'(MAX_RUN));
    assign cfg_ent = '{cnt: cfg_cnt, tgt: cfg_tgt};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [1:0]       fs, sl, we, take;
        logic [IW-1:0]    ptr [2];
        logic [TGT_W-1:0] cur_tgt [2];
        logic [TGT_W-1:0] tgt [2];
        logic [CNT_W-1:0] nxt_cnt [2];
        logic [CNT_W-1:0] head_cnt [2];

        assign fs = {tx_fs[p], rx_fs[p]};
        assign sl = {tx_slot[p], rx_slot[p]};

        // d = 0 receive, d = 1 transmit
        for (genvar d = 0; d < 2; d++) begin : g_dir
            assign we[d] = cfg_ok && (cfg_port == PW'(p)) && (cfg_tx == 1'(d));

            tsr_table #(.NENT(NENT)) u_tbl (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (we[d]),
                .wr_idx   (cfg_idx),
                .wr_ent   (cfg_ent),
                .swap     (fs[d]),
                .cur_idx  (ptr[d]),
                .nxt_idx  (ptr[d] + IW'(1)),
                .cur_tgt  (cur_tgt[d]),
                .nxt_cnt  (nxt_cnt[d]),
                .head_cnt (head_cnt[d])
            );

            tsr_walker #(.NENT(NENT)) u_walk (
                .clk         (clk),
                .rst_n       (rst_n),
                .frame_start (fs[d]),
                .slot_evt    (sl[d]),
                .head_cnt    (head_cnt[d]),
                .cur_tgt     (cur_tgt[d]),
                .nxt_cnt     (nxt_cnt[d]),
                .ptr         (ptr[d]),
                .tgt         (tgt[d]),
                .take        (take[d])
            );
        end

        tsr_rx_lane #(.NCH(NCH), .SLOT_W(SLOT_W)) u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take[0]),
            .tgt     (tgt[0]),
            .byte_in (rx_byte[p*SLOT_W +: SLOT_W]),
            .strb    (rx_dlv[p*NCH +: NCH]),
            .data    (rx_data[p*SLOT_W +: SLOT_W])
        );

        tsr_tx_lane #(.NCH(NCH), .SLOT_W(SLOT_W)) u_tx (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take[1]),
            .tgt   (tgt[1]),
            .src   (ch_tx_data),
            .pull  (tx_pull[p*NCH +: NCH]),
            .vld   (tx_vld[p]),
            .data  (tx_data[p*SLOT_W +: SLOT_W])
        );
    end
endmodule

// File: rtl/tsr_router_chk.sv
module tsr_router_chk #(
    parameter int NPORT  = 2,
    parameter int NCH    = 5,
    parameter int SLOT_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        rx_fs,
    input logic [NPORT-1:0]        rx_slot,
    input logic [NPORT-1:0]        tx_fs,
    input logic [NPORT-1:0]        tx_slot,
    input logic [NPORT*NCH-1:0]    rx_dlv,
    input logic [NPORT*NCH-1:0]    tx_pull,
    input logic [NPORT-1:0]        tx_vld,
    input logic [NPORT*SLOT_W-1:0] tx_data
);
    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        p_rx_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(rx_dlv[p*NCH +: NCH]));

        // R9: nothing is delivered without a slot event outside a frame start
        p_rx_needs_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(rx_slot[p] && !rx_fs[p]) |=> (rx_dlv[p*NCH +: NCH] == '0));

        p_tx_vld_on_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_slot[p] && !tx_fs[p]) |=> tx_vld[p]);

        p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(tx_slot[p] && !tx_fs[p]) |=> !tx_vld[p]);

        p_pull_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(tx_pull[p*NCH +: NCH]));

        p_pull_with_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|tx_pull[p*NCH +: NCH]) |-> tx_vld[p]);

        p_idle_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_vld[p] && !(|tx_pull[p*NCH +: NCH])) |-> (tx_data[p*SLOT_W +: SLOT_W] == '1));
    end
endmodule

bind tsr_router tsr_router_chk #(.NPORT(NPORT), .NCH(NCH), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/tsr_router_tb.sv
module tsr_router_tb;
    localparam int NP = 2;
    localparam int NC = 5;
    localparam int NE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_port = '0;
    logic        cfg_tx = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [6:0]  cfg_cnt = '0;
    logic [2:0]  cfg_tgt = '0;
    logic [3:0]  cfg_flags = '0;
    logic [1:0]  rx_fs = '0, rx_slot = '0, tx_fs = '0, tx_slot = '0;
    logic [15:0] rx_byte = '0;
    logic [39:0] ch_tx_data = '0;
    logic [9:0]  rx_dlv, tx_pull;
    logic [15:0] rx_data, tx_data;
    logic [1:0]  tx_vld;

    always #2 clk = ~clk;

    tsr_router u_dut (.*);

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model: [port][dir][entry], dir 0 receive, 1 transmit
    int sh_cnt [NP][2][NE];
    int sh_tgt [NP][2][NE];
    int ac_cnt [NP][2][NE];
    int ac_tgt [NP][2][NE];
    int sidx [NP][2];
    logic [9:0]  e_rx_dlv = '0, e_tx_pull = '0;
    logic [15:0] e_rx_data = '0, e_tx_data = '0;
    logic [1:0]  e_tx_vld = '0;

    function automatic int owner(int p, int d, int k);
        int sum = 0;
        for (int e = 0; e < NE; e++) begin
            if (ac_cnt[p][d][e] == 0) return 0;
            if (k < sum + ac_cnt[p][d][e]) return ac_tgt[p][d][e];
            sum += ac_cnt[p][d][e];
        end
        return 0;
    endfunction

    task automatic model_step();
        e_rx_dlv = '0; e_tx_pull = '0; e_tx_vld = '0;
        for (int p = 0; p < NP; p++) begin
            for (int d = 0; d < 2; d++) begin
                logic fs, sl;
                fs = d ? tx_fs[p] : rx_fs[p];
                sl = d ? tx_slot[p] : rx_slot[p];
                if (fs) begin
                    for (int e = 0; e < NE; e++) begin
                        ac_cnt[p][d][e] = sh_cnt[p][d][e];
                        ac_tgt[p][d][e] = sh_tgt[p][d][e];
                    end
                    sidx[p][d] = 0;
                end else if (sl) begin
                    int t;
                    t = owner(p, d, sidx[p][d]);
                    sidx[p][d]++;
                    if (d == 0) begin
                        if (t != 0) begin
                            e_rx_dlv[p*NC + t - 1] = 1'b1;
                            e_rx_data[p*8 +: 8] = rx_byte[p*8 +: 8];
                        end
                    end else begin
                        e_tx_vld[p] = 1'b1;
                        if (t != 0) begin
                            e_tx_pull[p*NC + t - 1] = 1'b1;
                            e_tx_data[p*8 +: 8] = ch_tx_data[(t-1)*8 +: 8];
                        end else begin
                            e_tx_data[p*8 +: 8] = 8'hFF;
                        end
                    end
                end
            end
        end
        if (cfg_we && cfg_flags == 0 && cfg_tgt <= 5 && cfg_cnt <= 64) begin
            sh_cnt[cfg_port][cfg_tx][cfg_idx] = int'(cfg_cnt);
            sh_tgt[cfg_port][cfg_tx][cfg_idx] = int'(cfg_tgt);
        end
    endtask

    task automatic chk(string field, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, field, got, exp, $time);
        end
    endtask

    // inputs are set after a falling edge; outputs compared after the next falling edge
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R5 rx_dlv", 16'(rx_dlv), 16'(e_rx_dlv));
        chk("R5 rx_data", rx_data, e_rx_data);
        chk("R6 tx_vld", 16'(tx_vld), 16'(e_tx_vld));
        chk("R6 tx_pull", 16'(tx_pull), 16'(e_tx_pull));
        chk("R6 tx_data", tx_data, e_tx_data);
        cfg_we = 1'b0; cfg_flags = '0;
        rx_fs = '0; tx_fs = '0; rx_slot = '0; tx_slot = '0;
        rx_byte = 16'($urandom); ch_tx_data = {8'($urandom), 32'($urandom)};
    endtask

    task automatic wr(int p, int d, int idx, int cnt, int tgt, int flg);
        cfg_we = 1'b1; cfg_port = 1'(p); cfg_tx = 1'(d); cfg_idx = 6'(idx);
        cfg_cnt = 7'(cnt); cfg_tgt = 3'(tgt); cfg_flags = 4'(flg);
        tick();
    endtask

    task automatic frame(logic [1:0] rxm, logic [1:0] txm);
        rx_fs = rxm; tx_fs = txm;
        tick();
    endtask

    task automatic run(int n, int gap, logic [1:0] rxm, logic [1:0] txm);
        for (int i = 0; i < n; i++) begin
            rx_slot = rxm; tx_slot = txm;
            tick();
            for (int g = 0; g < gap; g++) tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++)
            for (int d = 0; d < 2; d++) begin
                sidx[p][d] = 0;
                for (int e = 0; e < NE; e++) begin
                    sh_cnt[p][d][e] = 0; sh_tgt[p][d][e] = 0;
                    ac_cnt[p][d][e] = 0; ac_tgt[p][d][e] = 0;
                end
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then slots before any frame start are not used
        tag = "R1";
        tick();
        run(4, 0, 2'b11, 2'b11);

        // R3 R4: run-length tables with gaps, two ports, both directions
        tag = "R3 R4";
        wr(0, 0, 0, 2, 0, 0); wr(0, 0, 1, 24, 3, 0); wr(0, 0, 2, 1, 0, 0); wr(0, 0, 3, 5, 2, 0);
        wr(0, 1, 0, 2, 0, 0); wr(0, 1, 1, 24, 3, 0); wr(0, 1, 2, 1, 0, 0); wr(0, 1, 3, 5, 2, 0);
        wr(1, 0, 0, 3, 1, 0); wr(1, 0, 1, 4, 5, 0); wr(1, 0, 2, 2, 4, 0);
        wr(1, 1, 0, 1, 4, 0); wr(1, 1, 1, 6, 1, 0);
        frame(2'b11, 2'b11);
        run(36, 0, 2'b11, 2'b11);

        // R7: spaced slots past the end of the table, then full 64-entry table
        tag = "R7";
        frame(2'b11, 2'b11);
        run(35, 1, 2'b11, 2'b11);
        for (int e = 0; e < NE; e++) wr(1, 1, e, 1, (e % 5) + 1, 0);
        frame(2'b00, 2'b10);
        run(67, 0, 2'b00, 2'b10);

        // R8: mid-frame write held back; write coincident with frame start held one frame
        tag = "R8";
        frame(2'b01, 2'b00);
        run(3, 0, 2'b01, 2'b00);
        wr(0, 0, 1, 24, 5, 0);
        run(5, 0, 2'b01, 2'b00);
        cfg_we = 1'b1; cfg_port = 1'b0; cfg_tx = 1'b0; cfg_idx = 6'd0;
        cfg_cnt = 7'd2; cfg_tgt = 3'd1; cfg_flags = '0;
        frame(2'b01, 2'b00);
        run(4, 0, 2'b01, 2'b00);
        frame(2'b01, 2'b00);
        run(4, 0, 2'b01, 2'b00);

        // R2: rejected writes leave the table as it was; count 0 ends the table
        tag = "R2";
        wr(0, 0, 0, 3, 4, 1);
        wr(0, 0, 0, 3, 6, 0);
        wr(0, 0, 0, 65, 4, 0);
        frame(2'b01, 2'b00);
        run(6, 0, 2'b01, 2'b00);
        wr(0, 0, 2, 0, 0, 0);
        frame(2'b01, 2'b00);
        run(30, 0, 2'b01, 2'b00);

        // R9: slot coincident with frame start is dropped
        tag = "R9";
        rx_slot = 2'b11; tx_slot = 2'b11;
        frame(2'b11, 2'b11);
        run(5, 0, 2'b11, 2'b11);

        // R10: restart port 1 while port 0 keeps its walk
        tag = "R10";
        frame(2'b11, 2'b11);
        run(4, 0, 2'b11, 2'b11);
        frame(2'b10, 2'b10);
        run(8, 0, 2'b11, 2'b11);
        run(6, 2, 2'b01, 2'b10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule